// File: doc/BRIEF.md
# Triggered Single-Pulse Timer Channel

This block is one timer channel that sits idle until a start stimulus arrives and then emits an output pulse whose delay and width are both programmable. A counter, advanced by a prescaler tick enable, is compared with a compare register. The pulse starts when the count crosses the compare value and ends when the counter wraps at the reload value. In single-shot operation the counter disarms itself at that wrap, so exactly one pulse comes out per trigger. In repetitive operation the same waveform repeats every reload period.

The reload and compare values can each be written either straight into the working register or into a shadow copy that moves into the working register only at an update event. Software can force an update event to load both shadows and clear the counter before arming the channel. A fast-start option drives the reference to its post-match level on the trigger itself, which removes the compare latency from the front of the pulse. A polarity input selects an active-high or active-low output pin.

Top module: `opm_timer`

## Requirements
- R1: After reset the counter is stopped and holds 0, `oc_ref` is 0, `uev` is 0, and `oc_out` equals `polarity`.
- R2: Count up, mode 3'b111, tick every clock, trigger sampled on clock edge 0. `oc_ref` is 1 from edge C+1 through edge A+1, where C is the compare value and A the reload value. That is a delay of C counting ticks, then a pulse spanning count values C to A. `uev` is a one-clock pulse after edge A+1.
- R3: With `one_shot`=1, the wrap from reload to 0 clears the counter's run state. No later pulse or update event appears until the next trigger.
- R4: With `one_shot`=0, the pulse and the update event repeat every A+1 ticks.
- R5: Mode 3'b110 gives the inverse reference of mode 3'b111 for the same counter state. Counting up, the reference is active while count < C.
- R6: Counting down (`dir_down`=1), the counter runs from A to 0 and then reloads A with an update event. Mode 3'b110 is active while count <= C and mode 3'b111 while count > C.
- R7: With a preload enable at 1, a write to that register changes only its shadow copy, which moves to the working register at the next update event. With the enable at 0, the write takes effect on the next clock.
- R8: A one-clock `ug` request produces a `uev` pulse on the next clock. It loads both shadows into the working registers and sets the counter to 0 when counting up or to the reload value when counting down, without changing the run state.
- R9: With `fast_en`=1 in mode 3'b110 or 3'b111, a trigger drives `oc_ref` to its post-match level on the next clock. It holds that level until the wrap, so the pulse ends at the same edge as without fast start.
- R10: `oc_out` equals `oc_ref` when `polarity` is 0 and its inverse when `polarity` is 1.
- R11: While `tick_en` is 0 the counter holds its value even when running. Counting resumes on the first clock with `tick_en` at 1.
- R12: A trigger that arrives in the same clock as a single-shot wrap keeps the counter running, so a second full pulse follows.
- R13: Mode 3'b101 forces `oc_ref` to 1 and mode 3'b100 forces it to 0 on the next clock. Mode 3'b000 holds the current level. Every other code holds as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaler tick; counter advances only when high |
| trig | input | 1 | One-clock start pulse from the trigger source |
| one_shot | input | 1 | 1: stop at the first wrap; 0: repeat |
| dir_down | input | 1 | 0: count up; 1: count down |
| oc_mode | input | 3 | Output mode code (000 hold, 100 low, 101 high, 110 PWM1, 111 PWM2) |
| fast_en | input | 1 | Force post-match level on trigger |
| polarity | input | 1 | 0: active-high pin; 1: active-low pin |
| arr_pe | input | 1 | Reload preload enable |
| ccr_pe | input | 1 | Compare preload enable |
| wr_arr | input | 1 | Write strobe for the reload value |
| wr_ccr | input | 1 | Write strobe for the compare value |
| wr_data | input | CNT_W | Write data for either register |
| ug | input | 1 | Software update request |
| oc_ref | output | 1 | Reference waveform |
| oc_out | output | 1 | Polarity-adjusted output pin |
| uev | output | 1 | One-clock update-event flag |

## Verification
Two things can land in the same clock: the single-shot wrap that disarms the counter, and a fresh trigger that arms it. The bench fires a second trigger exactly on the wrap cycle of a running single-shot pulse and expects a second complete pulse with its own update event, followed by a stop. A software update request also lands in the middle of a running count. The expected waveform is then a short first pulse, a restart from zero and a normal ending, with two update events. Preload loading at an update event is judged the same way, by the shape of the pulse that follows.

// File: rtl/opm_pkg.sv
package opm_pkg;

    typedef enum logic [2:0] {
        OCM_HOLD     = 3'b000,
        OCM_FORCE_LO = 3'b100,
        OCM_FORCE_HI = 3'b101,
        OCM_PWM1     = 3'b110,
        OCM_PWM2     = 3'b111
    } oc_mode_e;

    typedef enum logic {
        CNT_UP   = 1'b0,
        CNT_DOWN = 1'b1
    } cnt_dir_e;

    // index of each programmable register in the register bank
    localparam int REG_RELOAD  = 0;
    localparam int REG_COMPARE = 1;
    localparam int NUM_REGS    = 2;

    typedef struct packed {
        logic run;    // counter armed
        logic wrap;   // rollover happens at this edge
        logic event_now; // update event happens at this edge
    } cnt_stat_t;

    function automatic logic is_pwm(oc_mode_e m);
        return (m == OCM_PWM1) || (m == OCM_PWM2);
    endfunction

    // level the reference takes right after a compare match
    function automatic logic match_level(oc_mode_e m, cnt_dir_e d);
        return (m == OCM_PWM2) ^ (d == CNT_DOWN);
    endfunction

    function automatic logic pwm_level(oc_mode_e m, logic past);
        return (m == OCM_PWM2) ? past : !past;
    endfunction

endpackage

// File: rtl/opm_regs.sv
module opm_regs
    import opm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_arr,
    input  logic             wr_ccr,
    input  logic             arr_pe,
    input  logic             ccr_pe,
    input  logic [CNT_W-1:0] wdata,
    input  logic             load,
    output logic [CNT_W-1:0] arr_act,
    output logic [CNT_W-1:0] arr_nxt,
    output logic [CNT_W-1:0] ccr_act
);

    logic [NUM_REGS-1:0]            wr;
    logic [NUM_REGS-1:0]            pe;
    logic [NUM_REGS-1:0][CNT_W-1:0] shadow_q;
    logic [NUM_REGS-1:0][CNT_W-1:0] act_q;
    logic [NUM_REGS-1:0][CNT_W-1:0] act_d;

    assign wr[REG_RELOAD]  = wr_arr;
    assign wr[REG_COMPARE] = wr_ccr;
    assign pe[REG_RELOAD]  = arr_pe;
    assign pe[REG_COMPARE] = ccr_pe;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [CNT_W-1:0] RST_VAL = (i == REG_RELOAD) ? '1 : '0;

        always_comb begin
            act_d[i] = act_q[i];
            if (wr[i] && !pe[i]) begin
                act_d[i] = wdata;
            end else if (load) begin
                act_d[i] = wr[i] ? wdata : shadow_q[i];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[i] <= RST_VAL;
                act_q[i]    <= RST_VAL;
            end else begin
                if (wr[i]) begin
                    shadow_q[i] <= wdata;
                end
                act_q[i] <= act_d[i];
            end
        end
    end

    assign arr_act = act_q[REG_RELOAD];
    assign arr_nxt = act_d[REG_RELOAD];
    assign ccr_act = act_q[REG_COMPARE];

endmodule

// File: rtl/opm_counter.sv
module opm_counter
    import opm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             trig,
    input  logic             ug,
    input  logic             one_shot,
    input  cnt_dir_e         dir,
    input  logic [CNT_W-1:0] arr_act,
    input  logic [CNT_W-1:0] arr_nxt,
    output logic [CNT_W-1:0] cnt,
    output cnt_stat_t        stat,
    output logic             uev
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d, restart_val;
    logic             run_q, run_d, uev_q;
    logic             step, wrap, evt;

    always_comb begin
        step        = run_q & tick_en;
        wrap        = step & ((dir == CNT_DOWN) ? (cnt_q == '0) : (cnt_q == arr_act));
        evt         = ug | wrap;
        restart_val = (dir == CNT_DOWN) ? arr_nxt : '0;

        if (evt) begin
            cnt_d = restart_val;
        end else if (step) begin
            cnt_d = (dir == CNT_DOWN) ? cnt_q - ONE : cnt_q + ONE;
        end else begin
            cnt_d = cnt_q;
        end

        // a new trigger outranks the single-shot disarm
        if (trig) begin
            run_d = 1'b1;
        end else if (one_shot && wrap) begin
            run_d = 1'b0;
        end else begin
            run_d = run_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            uev_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
            uev_q <= evt;
        end
    end

    assign cnt            = cnt_q;
    assign uev            = uev_q;
    assign stat.run       = run_q;
    assign stat.wrap      = wrap;
    assign stat.event_now = evt;

endmodule

// File: rtl/opm_compare.sv
module opm_compare
    import opm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] ccr,
    input  oc_mode_e         mode,
    input  cnt_dir_e         dir,
    input  logic             trig,
    input  logic             fast_en,
    input  logic             evt,
    output logic             oc_ref
);

    logic ref_q, ref_d;
    logic hold_q, hold_d;
    logic past, fast_set, forced;

    always_comb begin
        past     = (dir == CNT_DOWN) ? (cnt > ccr) : (cnt >= ccr);
        fast_set = trig & fast_en & is_pwm(mode);
        forced   = match_level(mode, dir);

        if (fast_set) begin
            hold_d = 1'b1;
        end else if (evt) begin
            hold_d = 1'b0;
        end else begin
            hold_d = hold_q;
        end

        case (mode)
            OCM_FORCE_LO: ref_d = 1'b0;
            OCM_FORCE_HI: ref_d = 1'b1;
            OCM_PWM1,
            OCM_PWM2:     ref_d = (fast_set || hold_q) ? forced : pwm_level(mode, past);
            default:      ref_d = ref_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            ref_q  <= ref_d;
            hold_q <= hold_d;
        end
    end

    assign oc_ref = ref_q;

endmodule

// File: rtl/opm_timer.sv
module opm_timer
    import opm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             trig,
    input  logic             one_shot,
    input  logic             dir_down,
    input  logic [2:0]       oc_mode,
    input  logic             fast_en,
    input  logic             polarity,
    input  logic             arr_pe,
    input  logic             ccr_pe,
    input  logic             wr_arr,
    input  logic             wr_ccr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ug,
    output logic             oc_ref,
    output logic             oc_out,
    output logic             uev
);

    oc_mode_e         mode;
    cnt_dir_e         dir;
    cnt_stat_t        stat;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] arr_act, arr_nxt, ccr_act;
    logic             run, wrap, evt;

    assign mode = oc_mode_e'(oc_mode);
    assign dir  = cnt_dir_e'(dir_down);
    assign run  = stat.run;
    assign wrap = stat.wrap;
    assign evt  = stat.event_now;

    opm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_arr  (wr_arr),
        .wr_ccr  (wr_ccr),
        .arr_pe  (arr_pe),
        .ccr_pe  (ccr_pe),
        .wdata   (wr_data),
        .load    (evt),
        .arr_act (arr_act),
        .arr_nxt (arr_nxt),
        .ccr_act (ccr_act)
    );

    opm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .trig     (trig),
        .ug       (ug),
        .one_shot (one_shot),
        .dir      (dir),
        .arr_act  (arr_act),
        .arr_nxt  (arr_nxt),
        .cnt      (cnt),
        .stat     (stat),
        .uev      (uev)
    );

    opm_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt),
        .ccr     (ccr_act),
        .mode    (mode),
        .dir     (dir),
        .trig    (trig),
        .fast_en (fast_en),
        .evt     (evt),
        .oc_ref  (oc_ref)
    );

    assign oc_out = oc_ref ^ polarity;

endmodule

// File: rtl/opm_checker.sv
module opm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             trig,
    input logic             ug,
    input logic             tick_en,
    input logic             one_shot,
    input logic             fast_en,
    input logic             dir_down,
    input logic [2:0]       oc_mode,
    input logic             ccr_pe,
    input logic             oc_ref,
    input logic             uev,
    input logic             run,
    input logic             wrap,
    input logic             evt,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] ccr_act
);

    AST_TRIG_ARMS: assert property (@(posedge clk) disable iff (rst)
        trig |=> run); // R2

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (rst)
        (one_shot && wrap && !trig) |=> !run); // R3

    AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ccr_pe && !evt) |=> $stable(ccr_act)); // R7

    AST_UG_EVENT: assert property (@(posedge clk) disable iff (rst)
        ug |=> uev); // R8

    AST_FAST_LEAD: assert property (@(posedge clk) disable iff (rst)
        (trig && fast_en && oc_mode == 3'b111 && !dir_down) |=> oc_ref); // R9

    AST_TICK_GATE: assert property (@(posedge clk) disable iff (rst)
        (run && !tick_en && !ug) |=> $stable(cnt)); // R11

    AST_FORCE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (oc_mode == 3'b101) |=> oc_ref); // R13

    AST_FORCE_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        (oc_mode == 3'b100) |=> !oc_ref); // R13

endmodule

bind opm_timer opm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .trig     (trig),
    .ug       (ug),
    .tick_en  (tick_en),
    .one_shot (one_shot),
    .fast_en  (fast_en),
    .dir_down (dir_down),
    .oc_mode  (oc_mode),
    .ccr_pe   (ccr_pe),
    .oc_ref   (oc_ref),
    .uev      (uev),
    .run      (run),
    .wrap     (wrap),
    .evt      (evt),
    .cnt      (cnt),
    .ccr_act  (ccr_act)
);

// File: tb/sim_opm_timer.sv
module sim_opm_timer;

    localparam int W = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic tick_en = 1'b1, trig = 1'b0, one_shot = 1'b1, dir_down = 1'b0;
    logic fast_en = 1'b0, polarity = 1'b0, arr_pe = 1'b0, ccr_pe = 1'b0;
    logic wr_arr = 1'b0, wr_ccr = 1'b0, ug = 1'b0;
    logic [2:0]   oc_mode = 3'b000;
    logic [W-1:0] wr_data = '0;
    logic oc_ref, oc_out, uev;

    opm_timer #(.CNT_W(W)) u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .trig(trig), .one_shot(one_shot),
        .dir_down(dir_down), .oc_mode(oc_mode), .fast_en(fast_en), .polarity(polarity),
        .arr_pe(arr_pe), .ccr_pe(ccr_pe), .wr_arr(wr_arr), .wr_ccr(wr_ccr),
        .wr_data(wr_data), .ug(ug), .oc_ref(oc_ref), .oc_out(oc_out), .uev(uev)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    cyc;
        bit    r;
        bit    o;
        bit    u;
        string tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // monitor: pops expectations whose cycle has come and compares at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc < cyc) begin
            cur = q.pop_front();
            checks++;
            errors++;
            $display("FAIL %s cyc %0d actual not sampled expected ref/out/uev %b%b%b",
                     cur.tag, cur.cyc, cur.r, cur.o, cur.u);
        end
        if (q.size() > 0 && q[0].cyc == cyc) begin
            cur = q.pop_front();
            checks++;
            if (oc_ref !== cur.r || oc_out !== cur.o || uev !== cur.u) begin
                errors++;
                $display("FAIL %s cyc %0d actual ref/out/uev %b%b%b expected %b%b%b",
                         cur.tag, cyc, oc_ref, oc_out, uev, cur.r, cur.o, cur.u);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_one(int k, bit r, bit u, string tag);
        exp_t e;
        e.cyc = k;
        e.r   = r;
        e.o   = r ^ polarity;
        e.u   = u;
        e.tag = tag;
        q.push_back(e);
    endtask

    // pulse windows [a+j*p, b+j*p] for j < reps; update flag at the end of each window
    task automatic push_span(int lo, int hi, int a, int b, int p, int reps, bit inv, string tag);
        for (int k = lo; k <= hi; k++) begin
            bit hit = 0;
            bit ev  = 0;
            for (int j = 0; j < reps; j++) begin
                if (k >= a + j * p && k <= b + j * p) hit = 1;
                if (k == b + j * p) ev = 1;
            end
            push_one(k, hit ^ inv, ev, tag);
        end
    endtask

    task automatic drain();
        while (q.size() > 0) step(1);
        step(1);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    task automatic write_reg(bit to_reload, int v);
        wr_data = W'(v);
        wr_arr  = to_reload;
        wr_ccr  = !to_reload;
        step(1);
        wr_arr  = 1'b0;
        wr_ccr  = 1'b0;
    endtask

    task automatic cfg(int c_val, int a_val);
        write_reg(1'b0, c_val);
        write_reg(1'b1, a_val);
        step(1);
    endtask

    initial begin
        int c;
        int d;
        step(3);
        rst = 1'b0;
        // R1: reset state
        c = cyc;
        for (int k = 1; k <= 4; k++) push_one(c + k, 1'b0, 1'b0, "R1");
        step(5);

        // R2 and R3: single-shot PWM2 pulse, compare 3, reload 7, then silence
        cfg(3, 7);
        oc_mode = 3'b111;
        step(3);
        c = cyc;
        trig = 1'b1;
        push_span(c + 1, c + 20, c + 5, c + 9, 8, 1, 1'b0, "R2/R3");
        step(1);
        trig = 1'b0;
        drain();

        // R10: inverted pin
        polarity = 1'b1;
        step(2);
        c = cyc;
        trig = 1'b1;
        push_span(c + 1, c + 14, c + 5, c + 9, 8, 1, 1'b0, "R10");
        step(1);
        trig = 1'b0;
        drain();
        polarity = 1'b0;

        // R5: PWM1 gives the inverse reference
        oc_mode = 3'b110;
        step(3);
        c = cyc;
        trig = 1'b1;
        push_span(c + 1, c + 16, c + 5, c + 9, 8, 1, 1'b1, "R5");
        step(1);
        trig = 1'b0;
        drain();

        // R9: fast start
        oc_mode = 3'b111;
        fast_en = 1'b1;
        step(3);
        c = cyc;
        trig = 1'b1;
        push_span(c + 1, c + 16, c + 1, c + 9, 8, 1, 1'b0, "R9");
        step(1);
        trig = 1'b0;
        drain();
        fast_en = 1'b0;

        // R13: forced levels and hold
        c = cyc;
        oc_mode = 3'b101;
        for (int k = 1; k <= 3; k++) push_one(c + k, 1'b1, 1'b0, "R13");
        step(3);
        c = cyc;
        oc_mode = 3'b000;
        for (int k = 1; k <= 3; k++) push_one(c + k, 1'b1, 1'b0, "R13");
        step(3);
        c = cyc;
        oc_mode = 3'b100;
        for (int k = 1; k <= 3; k++) push_one(c + k, 1'b0, 1'b0, "R13");
        step(3);
        drain();
        oc_mode = 3'b111;

        // R4: repetitive mode, three periods of 5
        one_shot = 1'b0;
        cfg(2, 4);
        step(2);
        c = cyc;
        trig = 1'b1;
        push_span(c + 1, c + 16, c + 4, c + 6, 5, 3, 1'b0, "R4");
        step(1);
        trig = 1'b0;
        drain();
        do_reset();
        one_shot = 1'b1;

        // R11: tick gating
        cfg(2, 5);
        step(2);
        tick_en = 1'b0;
        c = cyc;
        trig = 1'b1;
        for (int k = 1; k <= 6; k++) push_one(c + k, 1'b0, 1'b0, "R11");
        step(1);
        trig = 1'b0;
        step(5);
        d = cyc;
        tick_en = 1'b1;
        push_span(d + 1, d + 12, d + 3, d + 6, 6, 1, 1'b0, "R11");
        drain();

        // R12: trigger on the single-shot wrap cycle
        cfg(2, 4);
        step(2);
        c = cyc;
        trig = 1'b1;
        push_span(c + 1, c + 16, c + 4, c + 6, 5, 2, 1'b0, "R12");
        step(1);
        trig = 1'b0;
        step(4);
        trig = 1'b1;
        step(1);
        trig = 1'b0;
        drain();

        // R7: preload holds new values until the update event
        cfg(3, 7);
        arr_pe = 1'b1;
        ccr_pe = 1'b1;
        write_reg(1'b0, 1);
        write_reg(1'b1, 3);
        step(2);
        c = cyc;
        trig = 1'b1;
        push_span(c + 1, c + 12, c + 5, c + 9, 8, 1, 1'b0, "R7");
        step(1);
        trig = 1'b0;
        drain();
        c = cyc;
        trig = 1'b1;
        push_span(c + 1, c + 10, c + 3, c + 5, 4, 1, 1'b0, "R7");
        step(1);
        trig = 1'b0;
        drain();

        // R8: software update loads the shadows
        write_reg(1'b0, 2);
        write_reg(1'b1, 5);
        step(1);
        c = cyc;
        ug = 1'b1;
        push_one(c + 1, 1'b0, 1'b1, "R8");
        push_one(c + 2, 1'b0, 1'b0, "R8");
        step(1);
        ug = 1'b0;
        drain();
        c = cyc;
        trig = 1'b1;
        push_span(c + 1, c + 12, c + 4, c + 7, 6, 1, 1'b0, "R8");
        step(1);
        trig = 1'b0;
        drain();
        arr_pe = 1'b0;
        ccr_pe = 1'b0;

        // R6: down counting with PWM1, compare 3, reload 7
        dir_down = 1'b1;
        cfg(3, 7);
        ug = 1'b1;
        step(1);
        ug = 1'b0;
        step(1);
        oc_mode = 3'b110;
        step(3);
        c = cyc;
        trig = 1'b1;
        push_span(c + 1, c + 16, c + 6, c + 9, 8, 1, 1'b0, "R6");
        step(1);
        trig = 1'b0;
        drain();
        dir_down = 1'b0;
        oc_mode = 3'b111;
        do_reset();

        // R8: update request in the middle of a running count restarts it
        cfg(2, 4);
        step(2);
        c = cyc;
        trig = 1'b1;
        for (int k = c + 1; k <= c + 14; k++) begin
            push_one(k, (k == c + 4) || (k >= c + 7 && k <= c + 9),
                     (k == c + 4) || (k == c + 9), "R8");
        end
        step(1);
        trig = 1'b0;
        step(2);
        ug = 1'b1;
        step(1);
        ug = 1'b0;
        drain();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule